// File: doc/BRIEF.md
# Data Cache Line Maintenance Controller

This block performs single-line maintenance on a set-associative write-back data cache. A request names one of two operations, clean-and-drop (flush) or drop-only (invalidate), together with a line address and a privilege flag. The controller registers the request, presents the set index to the cache tag array, and compares the returned tags of every way. It then decides whether to invalidate the matching line and whether modified data must first go out to memory.

For a flush of a modified line, the whole line is copied into a local copyback buffer in the same cycle that the cache line is invalidated. The buffer is then written out one word at a time through a valid/ready memory write port. If that port reports an error, the remaining words are dropped, a sticky error bit is set and a one-cycle machine-check pulse is raised. The captured line stays readable from the buffer. Only invalidate is restricted to supervisor callers. The controller does not look at cache-enable or line-lock state, so both operations act the same whether or not the cache is enabled and whether or not the line is locked. An access-class output tells the protection logic to treat a flush as a read and an invalidate as a write.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: A flush (req_op=0) that hits a valid line with its dirty bit set invalidates that way and set, then writes LINE_WORDS words from the copyback buffer to consecutive word addresses starting at the line's base byte address, lowest word first, and raises done one cycle after the last write is accepted.
- R2: A flush that hits a valid clean line invalidates it with no memory write and raises done.
- R3: A request whose tag matches no valid way in the indexed set, whether flush or invalidate, performs no invalidation and no memory write, and raises done.
- R4: A supervisor invalidate (req_op=1, req_super=1) that hits invalidates the line even if it is dirty, and writes nothing to memory.
- R5: An invalidate with req_super=0 raises priv_fault together with done, invalidates nothing and writes nothing. A flush with req_super=0 proceeds as for a supervisor.
- R6: An error reported on an accepted write during a flush sets err_sticky, raises mcheck for one cycle together with done, and stops the write-back so that no further words are written.
- R7: After a flush, and in particular after a write error, cb_rd_data returns word cb_rd_sel of the flushed line until the next dirty flush reloads the buffer.
- R8: err_sticky stays set until err_clr is pulsed. err_clr clears it, and a new error in the same cycle keeps it set.
- R9: acc_store is 0 when req_op selects a flush and 1 when it selects an invalidate.
- R10: req_ready is high only when the controller is idle. A request presented while it is busy is ignored.
- R11: Every accepted request yields exactly one single-cycle done pulse. While mem_wr_valid waits for mem_wr_ready, the address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_op | input | 1 | 0 = flush, 1 = invalidate |
| req_line | input | AW-OFFB | Line address (tag and index) |
| req_super | input | 1 | 1 = supervisor caller |
| req_ready | output | 1 | Controller idle and accepting |
| acc_store | output | 1 | Access class for protection checking, 1 = write |
| tag_idx | output | IDXW | Set index presented to the tag array |
| way_tag | input | WAYS*TAGW | Tags of all ways in the indexed set |
| way_valid | input | WAYS | Valid bits of the indexed set |
| way_dirty | input | WAYS | Modified bits of the indexed set |
| line_way | output | WAYW | Way whose line data is requested |
| line_data | input | LINE_WORDS*DW | Line contents of the indexed set and line_way, word 0 in the low bits |
| inv_valid | output | 1 | Invalidate strobe to the tag array |
| inv_idx | output | IDXW | Set to invalidate |
| inv_way | output | WAYW | Way to invalidate |
| mem_wr_valid | output | 1 | Write-back word valid |
| mem_wr_addr | output | AW | Byte address of the word |
| mem_wr_data | output | DW | Word data |
| mem_wr_ready | input | 1 | Memory accepts the word |
| mem_wr_err | input | 1 | Error on the accepted word, qualified by mem_wr_ready |
| done | output | 1 | Request finished, one-cycle pulse |
| priv_fault | output | 1 | Privilege refusal, pulses with done |
| mcheck | output | 1 | Machine-check pulse on a write-back error |
| err_sticky | output | 1 | Sticky write-back error status |
| err_clr | input | 1 | Clears err_sticky |
| cb_rd_sel | input | CNTW | Word select for copyback buffer readout |
| cb_rd_data | output | DW | Selected copyback buffer word |

## Verification
The main function is driven with lines in each combination of state (dirty, clean, absent) under both operations and both privilege levels. These patterns separate write-back from plain invalidation, show which refusals depend on privilege, and confirm that a miss does nothing. The dirty flush runs once with a memory that is always ready and once with a memory that stalls on alternate cycles. This tells correct word order and stable handshake data apart from designs that advance on valid alone. An error injected on the middle word shows whether the write-back stops early, whether the status bit is kept, and whether the buffer still holds the data. A request issued during a drain shows whether busy-time requests are ignored.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOOK  = 2'd1,
      ST_DRAIN = 2'd2
   } dcm_state_t;

   localparam logic OP_FLUSH = 1'b0;
   localparam logic OP_INVAL = 1'b1;
endpackage

// File: rtl/dcm_hit.sv
module dcm_hit #(
   parameter int WAYS = 2,
   parameter int TAGW = 24,
   parameter int WAYW = 1
) (
   input  logic [WAYS*TAGW-1:0] way_tag,
   input  logic [WAYS-1:0]      way_valid,
   input  logic [WAYS-1:0]      way_dirty,
   input  logic [TAGW-1:0]      tag,
   output logic                 hit,
   output logic                 hit_dirty,
   output logic [WAYW-1:0]      hit_way
);
   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_valid[w] && (way_tag[w*TAGW +: TAGW] == tag);
   end

   always_comb begin
      hit       = 1'b0;
      hit_dirty = 1'b0;
      hit_way   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) begin
            hit       = 1'b1;
            hit_dirty = way_dirty[w];
            hit_way   = WAYW'(w);
         end
      end
   end
endmodule

// File: rtl/dcm_cbuf.sv
module dcm_cbuf #(
   parameter int LINE_WORDS = 4,
   parameter int DW         = 32,
   parameter int CNTW       = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [LINE_WORDS*DW-1:0] line_in,
   input  logic [CNTW-1:0]          drain_sel,
   input  logic [CNTW-1:0]          peek_sel,
   output logic [DW-1:0]            drain_word,
   output logic [DW-1:0]            peek_word
);
   logic [LINE_WORDS-1:0][DW-1:0] buf_q;

   for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)    buf_q[i] <= '0;
         else if (load) buf_q[i] <= line_in[i*DW +: DW];
      end
   end

   assign drain_word = buf_q[drain_sel];
   assign peek_word  = buf_q[peek_sel];

   // R7
   cb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(buf_q));
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
   import dcm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 16,
   parameter int WAYS       = 2,
   localparam int BYTEB     = $clog2(DW / 8),
   localparam int CNTW      = $clog2(LINE_WORDS),
   localparam int OFFB      = CNTW + BYTEB,
   localparam int IDXW      = $clog2(SETS),
   localparam int TAGW      = AW - IDXW - OFFB,
   localparam int WAYW      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_op,
   input  logic [AW-OFFB-1:0]       req_line,
   input  logic                     req_super,
   output logic                     req_ready,
   output logic                     acc_store,
   output logic [IDXW-1:0]          tag_idx,
   input  logic [WAYS*TAGW-1:0]     way_tag,
   input  logic [WAYS-1:0]          way_valid,
   input  logic [WAYS-1:0]          way_dirty,
   output logic [WAYW-1:0]          line_way,
   input  logic [LINE_WORDS*DW-1:0] line_data,
   output logic                     inv_valid,
   output logic [IDXW-1:0]          inv_idx,
   output logic [WAYW-1:0]          inv_way,
   output logic                     mem_wr_valid,
   output logic [AW-1:0]            mem_wr_addr,
   output logic [DW-1:0]            mem_wr_data,
   input  logic                     mem_wr_ready,
   input  logic                     mem_wr_err,
   output logic                     done,
   output logic                     priv_fault,
   output logic                     mcheck,
   output logic                     err_sticky,
   input  logic                     err_clr,
   input  logic [CNTW-1:0]          cb_rd_sel,
   output logic [DW-1:0]            cb_rd_data
);
   if (DW < 8 || (DW % 8) != 0 || (1 << BYTEB) != DW / 8) begin : g_bad_dw
      $error("DW must be a power-of-two multiple of 8");
   end
   if (LINE_WORDS < 2 || (1 << CNTW) != LINE_WORDS) begin : g_bad_lw
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << IDXW) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 1 || TAGW < 1) begin : g_bad_geom
      $error("WAYS must be positive and the address must leave tag bits");
   end

   dcm_state_t           state_q;
   logic                 op_q, super_q;
   logic [AW-OFFB-1:0]   line_q;
   logic [CNTW-1:0]      cnt_q;
   logic                 done_q, fault_q, mcheck_q, sticky_q;
   logic                 hit, hit_dirty, allowed, load_cb, err_evt, last_evt;
   logic [WAYW-1:0]      hit_way;
   logic [DW-1:0]        drain_word;

   assign tag_idx   = line_q[IDXW-1:0];
   assign req_ready = (state_q == ST_IDLE);
   assign acc_store = (req_op == OP_INVAL);

   dcm_hit #(.WAYS(WAYS), .TAGW(TAGW), .WAYW(WAYW)) hit_i (
      .way_tag   (way_tag),
      .way_valid (way_valid),
      .way_dirty (way_dirty),
      .tag       (line_q[AW-OFFB-1:IDXW]),
      .hit       (hit),
      .hit_dirty (hit_dirty),
      .hit_way   (hit_way)
   );

   assign allowed   = !(op_q == OP_INVAL && !super_q);
   assign line_way  = hit_way;
   assign inv_valid = (state_q == ST_LOOK) && allowed && hit;
   assign inv_idx   = tag_idx;
   assign inv_way   = hit_way;
   assign load_cb   = inv_valid && (op_q == OP_FLUSH) && hit_dirty;

   dcm_cbuf #(.LINE_WORDS(LINE_WORDS), .DW(DW), .CNTW(CNTW)) cbuf_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_cb),
      .line_in    (line_data),
      .drain_sel  (cnt_q),
      .peek_sel   (cb_rd_sel),
      .drain_word (drain_word),
      .peek_word  (cb_rd_data)
   );

   assign mem_wr_valid = (state_q == ST_DRAIN);
   assign mem_wr_addr  = {line_q, cnt_q, BYTEB'(0)};
   assign mem_wr_data  = drain_word;
   assign err_evt      = mem_wr_valid && mem_wr_ready && mem_wr_err;
   assign last_evt     = mem_wr_valid && mem_wr_ready && !mem_wr_err
                         && (cnt_q == CNTW'(LINE_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= OP_FLUSH;
         super_q  <= 1'b0;
         line_q   <= '0;
         cnt_q    <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         mcheck_q <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         mcheck_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q    <= req_op;
                  super_q <= req_super;
                  line_q  <= req_line;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               cnt_q <= '0;
               if (load_cb) begin
                  state_q <= ST_DRAIN;
               end else begin
                  fault_q <= !allowed;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_DRAIN: begin
               if (err_evt) begin
                  mcheck_q <= 1'b1;
                  done_q   <= 1'b1;
                  state_q  <= ST_IDLE;
               end else if (last_evt) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (mem_wr_ready) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       sticky_q <= 1'b0;
      else if (err_evt) sticky_q <= 1'b1;
      else if (err_clr) sticky_q <= 1'b0;
   end

   assign done       = done_q;
   assign priv_fault = fault_q;
   assign mcheck     = mcheck_q;
   assign err_sticky = sticky_q;

   // R11
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
   // R5
   user_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault |-> done && !mem_wr_valid);
   // R6
   mcheck_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mcheck |-> done && err_sticky);
   // R8
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky && !err_clr |=> err_sticky);
   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid || inv_valid) |-> !req_ready);
   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && mem_wr_ready && mem_wr_err |=> !mem_wr_valid);
endmodule

// File: tb/dcache_maint_ctrl_tb_top.sv
module dcache_maint_ctrl_tb_top;
   localparam int AW = 32, DW = 32, LW = 4, SETS = 16, WAYS = 2;
   localparam int OFFB = 4, IDXW = 4, TAGW = 24, WAYW = 1, CNTW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic                 req_valid = 0, req_op = 0, req_super = 0;
   logic [AW-OFFB-1:0]   req_line = '0;
   logic                 req_ready, acc_store;
   logic [IDXW-1:0]      tag_idx, inv_idx;
   logic [WAYS*TAGW-1:0] way_tag;
   logic [WAYS-1:0]      way_valid, way_dirty;
   logic [WAYW-1:0]      line_way, inv_way;
   logic [LW*DW-1:0]     line_data;
   logic                 inv_valid, mem_wr_valid, mem_wr_ready, mem_wr_err;
   logic [AW-1:0]        mem_wr_addr;
   logic [DW-1:0]        mem_wr_data;
   logic                 done, priv_fault, mcheck, err_sticky;
   logic                 err_clr = 0;
   logic [CNTW-1:0]      cb_rd_sel = '0;
   logic [DW-1:0]        cb_rd_data;

   dcache_maint_ctrl #(.AW(AW), .DW(DW), .LINE_WORDS(LW), .SETS(SETS), .WAYS(WAYS)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
      .req_super(req_super), .req_ready(req_ready), .acc_store(acc_store), .tag_idx(tag_idx),
      .way_tag(way_tag), .way_valid(way_valid), .way_dirty(way_dirty), .line_way(line_way),
      .line_data(line_data), .inv_valid(inv_valid), .inv_idx(inv_idx), .inv_way(inv_way),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ready(mem_wr_ready), .mem_wr_err(mem_wr_err), .done(done), .priv_fault(priv_fault),
      .mcheck(mcheck), .err_sticky(err_sticky), .err_clr(err_clr), .cb_rd_sel(cb_rd_sel),
      .cb_rd_data(cb_rd_data)
   );

   // cache tag array model
   logic [TAGW-1:0] tg [SETS][WAYS];
   logic            vl [SETS][WAYS];
   logic            dt [SETS][WAYS];

   function automatic logic [DW-1:0] mk(int s, int w, int i);
      return 32'hA500_0000 ^ (s << 12) ^ (w << 8) ^ i;
   endfunction

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         way_tag[w*TAGW +: TAGW] = tg[tag_idx][w];
         way_valid[w]            = vl[tag_idx][w];
         way_dirty[w]            = dt[tag_idx][w];
      end
      for (int i = 0; i < LW; i++) line_data[i*DW +: DW] = mk(int'(tag_idx), int'(line_way), i);
   end

   // memory model and event counters
   int  wr_n = 0, inv_n = 0, done_n = 0, fault_n = 0, mc_n = 0, cyc = 0;
   logic [AW-1:0] wa [64];
   logic [DW-1:0] wd [64];
   logic stall = 0, err_arm = 0;
   int   err_at = 0;
   assign mem_wr_ready = !stall || cyc[0];
   assign mem_wr_err   = err_arm && (wr_n == err_at);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (mem_wr_valid && mem_wr_ready) begin
            wa[wr_n[5:0]] <= mem_wr_addr;
            wd[wr_n[5:0]] <= mem_wr_data;
            wr_n <= wr_n + 1;
         end
         if (inv_valid) begin
            vl[inv_idx][inv_way] <= 1'b0;
            inv_n <= inv_n + 1;
         end
         if (done)       done_n  <= done_n + 1;
         if (priv_fault) fault_n <= fault_n + 1;
         if (mcheck)     mc_n    <= mc_n + 1;
      end
   end

   int errors = 0, checks = 0;
   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [AW-OFFB-1:0] ln(int t, int s);
      return {TAGW'(t), IDXW'(s)};
   endfunction

   int w0, i0, d0, f0, m0;
   task automatic snap();
      w0 = wr_n; i0 = inv_n; d0 = done_n; f0 = fault_n; m0 = mc_n;
   endtask

   task automatic run_op(logic op, logic [AW-OFFB-1:0] line, logic sup);
      snap();
      @(negedge clk);
      req_valid = 1; req_op = op; req_line = line; req_super = sup;
      @(negedge clk);
      req_valid = 0;
      for (int k = 0; k < 100 && done_n == d0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(req_ready == 1 && done == 0 && mem_wr_valid == 0 && inv_valid == 0,
          "R10", "idle outputs after reset", {req_ready, done, mem_wr_valid, inv_valid}, 4'b1000);
      chk(err_sticky == 0, "R8", "sticky after reset", err_sticky, 0);
   endtask

   task automatic t_flush_dirty(int s, int w, int t, bit stl, string rq);
      stall = stl;
      run_op(0, ln(t, s), 1);
      chk(wr_n - w0 == LW, rq, "write count", wr_n - w0, LW);
      for (int i = 0; i < LW; i++) begin
         chk(wa[(w0 + i) % 64] == {ln(t, s), 4'(i * 4)}, rq, "write address", wa[(w0 + i) % 64], {ln(t, s), 4'(i * 4)});
         chk(wd[(w0 + i) % 64] == mk(s, w, i), rq, "write data", wd[(w0 + i) % 64], mk(s, w, i));
      end
      chk(inv_n - i0 == 1 && vl[s][w] == 0, rq, "line invalidated", vl[s][w], 0);
      chk(done_n - d0 == 1, "R11", "one done per request", done_n - d0, 1);
      stall = 0;
   endtask

   task automatic t_flush_clean();
      run_op(0, ln(24'h0BEEF, 7), 1);
      chk(wr_n == w0 && vl[7][1] == 0 && done_n - d0 == 1, "R2", "clean flush",
          {wr_n - w0, vl[7][1]}, 0);
   endtask

   task automatic t_miss();
      run_op(0, ln(24'h77777, 3), 1);
      chk(wr_n == w0 && inv_n == i0 && done_n - d0 == 1, "R3", "flush miss",
          {wr_n - w0, inv_n - i0}, 0);
      run_op(1, ln(24'h66666, 3), 1);
      chk(wr_n == w0 && inv_n == i0 && done_n - d0 == 1 && fault_n == f0, "R3", "invalidate miss",
          {wr_n - w0, inv_n - i0}, 0);
   endtask

   task automatic t_inval_super();
      run_op(1, ln(24'h0C0DE, 9), 1);
      chk(wr_n == w0 && vl[9][0] == 0 && inv_n - i0 == 1, "R4", "supervisor invalidate of dirty line",
          {wr_n - w0, vl[9][0]}, 0);
   endtask

   task automatic t_inval_user();
      run_op(1, ln(24'h0F00D, 10), 0);
      chk(fault_n - f0 == 1 && done_n - d0 == 1, "R5", "user invalidate faults", fault_n - f0, 1);
      chk(inv_n == i0 && wr_n == w0 && vl[10][1] == 1, "R5", "user invalidate leaves line",
          {inv_n - i0, vl[10][1]}, 1);
   endtask

   task automatic t_flush_user();
      run_op(0, ln(24'h0F00D, 10), 0);
      chk(wr_n - w0 == LW && vl[10][1] == 0 && fault_n == f0, "R5", "user flush allowed",
          wr_n - w0, LW);
   endtask

   task automatic t_bus_err();
      err_arm = 1; err_at = wr_n + 2;
      run_op(0, ln(24'h0DEAD, 5), 1);
      err_arm = 0;
      chk(wr_n - w0 == 3, "R6", "write-back stops at error", wr_n - w0, 3);
      chk(mc_n - m0 == 1 && err_sticky == 1, "R6", "mcheck and sticky", {mc_n - m0, err_sticky}, 2'b11);
      chk(vl[5][1] == 0, "R1", "line invalid after errored flush", vl[5][1], 0);
      for (int i = 0; i < LW; i++) begin
         cb_rd_sel = CNTW'(i);
         #1;
         chk(cb_rd_data == mk(5, 1, i), "R7", "copyback buffer word", cb_rd_data, mk(5, 1, i));
      end
   endtask

   task automatic t_sticky_clear();
      run_op(0, ln(24'h12121, 2), 1);
      chk(err_sticky == 1, "R8", "sticky held across later request", err_sticky, 1);
      cb_rd_sel = 2'd3; #1;
      chk(cb_rd_data == mk(5, 1, 3), "R7", "buffer kept after miss", cb_rd_data, mk(5, 1, 3));
      @(negedge clk); err_clr = 1;
      @(negedge clk); err_clr = 0;
      chk(err_sticky == 0, "R8", "sticky cleared", err_sticky, 0);
   endtask

   task automatic t_acc_class();
      req_op = 0; #1;
      chk(acc_store == 0, "R9", "flush classed as read", acc_store, 0);
      req_op = 1; #1;
      chk(acc_store == 1, "R9", "invalidate classed as write", acc_store, 1);
   endtask

   task automatic t_busy_ignored();
      stall = 1;
      snap();
      @(negedge clk);
      req_valid = 1; req_op = 0; req_line = ln(24'h0AAAA, 12); req_super = 1;
      @(negedge clk);
      req_op = 1; req_line = ln(24'h0BBBB, 13);
      repeat (3) @(negedge clk);
      chk(req_ready == 0 && mem_wr_valid == 1, "R10", "busy during drain", req_ready, 0);
      req_valid = 0;
      for (int k = 0; k < 100 && done_n == d0; k++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(done_n - d0 == 1 && vl[13][0] == 1 && inv_n - i0 == 1, "R10", "busy request ignored",
          {done_n - d0, vl[13][0]}, 2'b11);
      stall = 0;
   endtask

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            tg[s][w] = '0; vl[s][w] = 0; dt[s][w] = 0;
         end
      tg[3][0]  = 24'h12345; vl[3][0]  = 1; dt[3][0]  = 1;
      tg[6][1]  = 24'h54321; vl[6][1]  = 1; dt[6][1]  = 1;
      tg[7][1]  = 24'h0BEEF; vl[7][1]  = 1; dt[7][1]  = 0;
      tg[9][0]  = 24'h0C0DE; vl[9][0]  = 1; dt[9][0]  = 1;
      tg[10][1] = 24'h0F00D; vl[10][1] = 1; dt[10][1] = 1;
      tg[5][1]  = 24'h0DEAD; vl[5][1]  = 1; dt[5][1]  = 1;
      tg[12][0] = 24'h0AAAA; vl[12][0] = 1; dt[12][0] = 1;
      tg[13][0] = 24'h0BBBB; vl[13][0] = 1; dt[13][0] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_flush_dirty(3, 0, 24'h12345, 0, "R1");
      t_flush_dirty(6, 1, 24'h54321, 1, "R1");
      t_flush_clean();
      t_miss();
      t_inval_super();
      t_inval_user();
      t_flush_user();
      t_bus_err();
      t_sticky_clear();
      t_acc_class();
      t_busy_ignored();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule